// File: doc/BRIEF.md
# Hybrid BIST pattern broadcaster

This block produces test stimuli for several combinational cores at once. A single linear feedback shift register drives a shared test bus, and every core sees the same word in the same clock. A run has two phases. In the first, the shift register state is placed on the bus for a programmed number of clocks. In the second, the block steps through stored deterministic entries. Each entry carries a pattern word and a per-bit care mask. Cared bits come from the pattern. Uncared bits take the current shift register bits.

The shift register never restarts or pauses during a run. It advances on every clock that carries a pattern, including the clock at the switch from the first phase to the second. The filler bits of the stored patterns are therefore the natural continuation of the pseudorandom stream. The seed is sampled when a run starts, so the best starting state can be chosen for each run. The stored entries arrive on flat input buses, so the pattern memory can be a small ROM or register array outside the block.

Top module: `hbist_broadcaster`

## Requirements
- R1: While reset is asserted and just after it is released, valid_o, phase_o, done_o and bus_o are all 0.
- R2: start_i is accepted only while no run is in progress. Seed, LP and LD are sampled in the accepting clock, and the first pattern appears in the next clock. A start_i pulse during a run, and changes to seed_i, lp_len_i or ld_len_i during a run, have no effect on that run.
- R3: The generator is a 16-bit Fibonacci register with the default width. Each step shifts left and feeds bit 15 ^ bit 13 ^ bit 12 ^ bit 10 into bit 0. The first pseudorandom pattern equals the seed. A zero seed is replaced by 0x0001.
- R4: The pseudorandom phase lasts min(LP, LP_MAX) clocks with phase_o = 0 and valid_o = 1, and bus_o equals the register state.
- R5: The deterministic phase follows with phase_o = 1 and lasts min(LD, DEPTH) clocks. It applies entries 0, 1, 2 and so on in order. Entry k occupies bits [k*W +: W] of pat_mem_i and care_mem_i.
- R6: In the deterministic phase, bus bit i is the pattern bit where care bit i is 1, and the current register bit where care bit i is 0.
- R7: The register advances once per pattern clock, uninterrupted across the phase switch. The first deterministic entry uses the state that follows the last pseudorandom pattern.
- R8: done_o is high for exactly one clock, the clock after the last pattern of a run, and valid_o is low in that clock.
- R9: With LP = 0 the run begins directly with deterministic entries. With LD = 0 it ends after the pseudorandom phase. With both zero, done_o pulses in the clock after the start and no pattern is issued.
- R10: Whenever valid_o is 0, bus_o and phase_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (ignored while busy) |
| seed_i | input | W | Generator starting state |
| lp_len_i | input | LEN_W | Pseudorandom phase length |
| ld_len_i | input | LEN_W | Number of deterministic entries |
| pat_mem_i | input | DEPTH*W | Stored pattern words, entry k at [k*W +: W] |
| care_mem_i | input | DEPTH*W | Care masks, entry k at [k*W +: W] |
| bus_o | output | W | Broadcast test word |
| valid_o | output | 1 | Bus carries a pattern this clock |
| phase_o | output | 1 | 0 pseudorandom, 1 deterministic |
| done_o | output | 1 | One-clock end-of-run pulse |

## Verification
A behavioural model predicts the bus word, phase, valid and done signals for every clock. Runs use a mix of LP and LD values: a mixed run, a zero seed, LP zero, LD zero, both zero, and lengths above both limits. Together these separate a correct phase sequencer from one that miscounts, fails to clamp, or skips a phase.

The care masks include all-ones, all-zeros and mixed entries. The all-ones mask shows the stored word alone. The all-zeros mask shows the register stream alone, so a generator that restarts or pauses at the phase switch is exposed. The mixed masks show that the merge works bit by bit.

A start pulse and changed inputs in the middle of a run confirm that the run length and the stream are unaffected.

// File: rtl/hbist_broadcaster.sv
module hbist_broadcaster #(
  parameter int W      = 16,
  parameter int DEPTH  = 8,
  parameter int LP_MAX = 1000,
  parameter int LEN_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [W-1:0]       seed_i,
  input  logic [LEN_W-1:0]   lp_len_i,
  input  logic [LEN_W-1:0]   ld_len_i,
  input  logic [DEPTH*W-1:0] pat_mem_i,
  input  logic [DEPTH*W-1:0] care_mem_i,
  output logic [W-1:0]       bus_o,
  output logic               valid_o,
  output logic               phase_o,
  output logic               done_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LEN_W-1:0] LPM = LEN_W'(LP_MAX);
  localparam logic [LEN_W-1:0] LDM = LEN_W'(DEPTH);

  function automatic logic [31:0] tap_mask(int w);
    case (w)
      4:       return 32'h0000_000C;
      8:       return 32'h0000_00B8;
      12:      return 32'h0000_0829;
      24:      return 32'h00E1_0000;
      32:      return 32'h8020_0003;
      default: return 32'h0000_B400;
    endcase
  endfunction

  localparam logic [W-1:0] TAPS = W'(tap_mask(W));

  typedef enum logic [1:0] {S_IDLE, S_PR, S_DET} st_t;

  st_t              st;
  logic [LEN_W-1:0] cnt, lp_q, ld_q;
  logic [W-1:0]     lfsr;
  logic             done_q;

  wire [LEN_W-1:0] cnt_nx = cnt + 1'b1;
  wire [LEN_W-1:0] lp_eff = (lp_len_i > LPM) ? LPM : lp_len_i;
  wire [LEN_W-1:0] ld_eff = (ld_len_i > LDM) ? LDM : ld_len_i;
  wire [W-1:0]     lfsr_step = {lfsr[W-2:0], ^(lfsr & TAPS)};
  wire [IW-1:0]    sel  = cnt[IW-1:0];
  wire [W-1:0]     pat  = pat_mem_i[int'(sel)*W +: W];
  wire [W-1:0]     care = care_mem_i[int'(sel)*W +: W];
  wire [W-1:0]     merged = (pat & care) | (lfsr & ~care);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cnt    <= '0;
      lp_q   <= '0;
      ld_q   <= '0;
      lfsr   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          lfsr <= (seed_i == '0) ? W'(1) : seed_i;
          lp_q <= lp_eff;
          ld_q <= ld_eff;
          cnt  <= '0;
          if (lp_eff != '0)      st <= S_PR;
          else if (ld_eff != '0) st <= S_DET;
          else                   done_q <= 1'b1;
        end
        S_PR: begin
          lfsr <= lfsr_step;
          cnt  <= cnt_nx;
          if (cnt_nx == lp_q) begin
            cnt <= '0;
            if (ld_q != '0) st <= S_DET;
            else begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_DET: begin
          lfsr <= lfsr_step;
          cnt  <= cnt_nx;
          if (cnt_nx == ld_q) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign valid_o = (st != S_IDLE);
  assign phase_o = (st == S_DET);
  assign bus_o   = (st == S_PR) ? lfsr : (st == S_DET) ? merged : '0;
  assign done_o  = done_q;
endmodule

// File: rtl/hbist_broadcaster_chk.sv
module hbist_broadcaster_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] bus_o,
  input logic         valid_o,
  input logic         phase_o,
  input logic         done_o
);
  a_r3_nonzero_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !phase_o) |-> (bus_o != '0));

  a_r7_shift_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !phase_o && $past(valid_o) && !$past(phase_o))
      |-> (bus_o[W-1:1] == $past(bus_o[W-2:0])));

  a_r5_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && phase_o) |=> !(valid_o && !phase_o));

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (valid_o || done_o));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (bus_o == '0 && !phase_o));
endmodule

bind hbist_broadcaster hbist_broadcaster_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bus_o   (bus_o),
  .valid_o (valid_o),
  .phase_o (phase_o),
  .done_o  (done_o)
);

// File: tb/tb_hbist_broadcaster.sv
module tb_hbist_broadcaster;
  localparam int W = 16, DEPTH = 8, LP_MAX = 1000, LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] seed = '0;
  logic [LEN_W-1:0] lp = '0, ld = '0;
  logic [DEPTH*W-1:0] pm, cm;
  logic [W-1:0] bus;
  logic valid, phase, done;

  hbist_broadcaster #(.W(W), .DEPTH(DEPTH), .LP_MAX(LP_MAX), .LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed),
    .lp_len_i(lp), .ld_len_i(ld), .pat_mem_i(pm), .care_mem_i(cm),
    .bus_o(bus), .valid_o(valid), .phase_o(phase), .done_o(done));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int m_st = 0, m_cnt = 0, m_lp = 0, m_ld = 0;
  logic [15:0] m_lfsr = '0;
  bit m_done = 0;
  int vcount = 0, dcount = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] nxt(logic [15:0] b);
    return {b[14:0], b[15] ^ b[13] ^ b[12] ^ b[10]};
  endfunction

  function automatic logic [15:0] mix(int k, logic [15:0] l);
    logic [15:0] p, c, r;
    p = pm[k*16 +: 16];
    c = cm[k*16 +: 16];
    for (int i = 0; i < 16; i++) r[i] = c[i] ? p[i] : l[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (start) begin
          m_lfsr = (seed == 0) ? 16'h0001 : seed;
          m_lp = (lp > LP_MAX) ? LP_MAX : int'(lp);
          m_ld = (ld > DEPTH) ? DEPTH : int'(ld);
          m_cnt = 0;
          if (m_lp > 0) m_st = 1;
          else if (m_ld > 0) m_st = 2;
          else m_done = 1;
        end
        1: begin
          m_lfsr = nxt(m_lfsr); m_cnt++;
          if (m_cnt == m_lp) begin
            m_cnt = 0;
            if (m_ld > 0) m_st = 2;
            else begin m_st = 0; m_done = 1; end
          end
        end
        default: begin
          m_lfsr = nxt(m_lfsr); m_cnt++;
          if (m_cnt == m_ld) begin m_st = 0; m_done = 1; end
        end
      endcase
    end
    #3;
    if (rst_n) begin
      chk("R4 R5 valid", {31'd0, valid}, {31'd0, m_st != 0});
      chk("R5 phase", {31'd0, phase}, {31'd0, m_st == 2});
      chk("R8 done", {31'd0, done}, {31'd0, m_done});
      if (m_st == 1)      chk("R3 R7 pseudorandom bus", {16'd0, bus}, {16'd0, m_lfsr});
      else if (m_st == 2) chk("R6 R7 merged bus", {16'd0, bus}, {16'd0, mix(m_cnt, m_lfsr)});
      else                chk("R10 idle bus", {16'd0, bus}, 32'd0);
      if (valid) vcount++;
      if (done) dcount++;
    end
  end

  task automatic run(string tag, logic [15:0] s, int l_p, int l_d, int exp_n, bit poke);
    @(negedge clk);
    seed = s; lp = LEN_W'(l_p); ld = LEN_W'(l_d); start = 1'b1;
    vcount = 0; dcount = 0;
    @(negedge clk);
    start = 1'b0; seed = 16'h0; lp = 3; ld = 1;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000 && dcount == 0; i++) @(negedge clk);
    chk({tag, " pattern count"}, vcount, exp_n);
    chk({tag, " done pulses"}, dcount, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      pm[k*16 +: 16] = 16'hA5A5 ^ 16'(k * 16'h1357);
      cm[k*16 +: 16] = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000
                     : (16'h00FF << k) | 16'(k);
    end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, valid}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset phase", {31'd0, phase}, 32'd0);
    chk("R1 reset bus", {16'd0, bus}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {16'd0, bus, 13'd0, valid, phase, done}, 32'd0);
    run("R2 mixed run with busy start", 16'hACE1, 20, 4, 24, 1'b1);
    run("R3 zero seed", 16'h0000, 5, 2, 7, 1'b0);
    run("R9 no pseudorandom phase", 16'h1234, 0, 3, 3, 1'b0);
    run("R9 no deterministic phase", 16'hBEEF, 7, 0, 7, 1'b0);
    run("R9 empty run", 16'h0F0F, 0, 0, 0, 1'b0);
    run("R4 R5 clamped lengths", 16'h8001, 2000, 12, LP_MAX + DEPTH, 1'b0);
    run("R7 all entries", 16'h5A5A, 1, 8, 9, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog R8 actual=no_done expected=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end
endmodule